// File: doc/BRIEF.md
# Clock-Stretch Low-Phase Width Trigger

This block watches a two-wire serial bus clock line (SCL) and times every low phase of it in ticks of a faster system clock. It is meant for bus monitors and debug capture logic: a peripheral that stretches the clock by holding SCL low keeps the line down longer than a normal low phase. The block raises a trigger as soon as that hold outlasts a programmable width, so the rare event can be captured while it is still in progress.

The raw line first passes through a multi-flop synchroniser and a short sliding-window filter, which remove metastability and narrow glitches. Each falling edge of the filtered line starts a saturating counter. When the count passes the threshold that was sampled at that edge, the block emits a single-cycle pulse and sets a sticky flag, but only while it is armed. On the following rising edge, the completed low width is stored in an output register. The threshold is usually set to about one nominal SCL period, for example 1000 ticks of a 100 MHz clock for a 100 kHz bus, so that ordinary low phases never fire. The block judges only duration; it does not care which device holds the line.

Top module: `scl_stretch_trigger`

## Requirements
- R1: After reset, trig_pulse, trig_sticky and low_len are 0. A low phase that is already in progress when reset is released is neither measured nor able to trigger; measurement resumes at the next falling edge.
- R2: A low or high excursion of SCL lasting a single system-clock cycle is ignored. In the default majority-of-3 filter it does not start, end or split a low phase.
- R3: On the rising edge that ends a low phase, low_len takes the number of system-clock cycles that SCL was low. Between such edges low_len does not change.
- R4: A low phase fires the trigger only if its length is strictly greater than the threshold. A length equal to the threshold does not fire.
- R5: A low phase produces at most one trig_pulse, one cycle wide, however long it lasts. The pulse occurs while the line is still low, before low_len is updated for that phase.
- R6: trig_sticky is set together with trig_pulse. It stays set until arm goes from 0 to 1, which clears it.
- R7: While arm is 0, no trig_pulse occurs, but low phases are still measured into low_len.
- R8: The threshold is sampled at each falling edge. A change of thr_ticks during a low phase applies only from the next falling edge.
- R9: The low-phase counter saturates at 2^CNT_W-1 and does not wrap. A longer phase reports low_len = 2^CNT_W-1 and still triggers once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line, asynchronous to clk |
| thr_ticks | input | CNT_W | Trigger width threshold in clk ticks |
| arm | input | 1 | 1 enables triggering; a 0-to-1 change clears trig_sticky |
| trig_pulse | output | 1 | One-cycle pulse when the current low phase exceeds the threshold |
| trig_sticky | output | 1 | Set by a trigger, held until re-arm |
| low_len | output | CNT_W | Length in ticks of the last completed low phase |

## Verification
The bench builds the block with CNT_W = 8, which brings counter saturation at 255 within a few hundred cycles. The synchroniser and filter keep their defaults: two stages and a majority-of-3 window, so single-cycle glitches are exactly at the rejection limit. With an 8-bit threshold, the equal-to and one-over boundaries, a threshold change in the middle of a phase, and a reset in the middle of a phase all fit in short directed scenarios.

// File: rtl/sst_pkg.sv
package sst_pkg;
   // Variant of the SCL glitch filter
   typedef enum logic {
      FILT_MAJORITY  = 1'b0,  // output follows majority of the window
      FILT_UNANIMOUS = 1'b1   // output changes only when the window agrees
   } filt_mode_e;
endpackage

// File: rtl/sst_scl_conditioner.sv
module sst_scl_conditioner #(
   parameter int                 SYNC_STAGES = 2,
   parameter int                 FILT_LEN    = 3,
   parameter sst_pkg::filt_mode_e FILT_MODE  = sst_pkg::FILT_MAJORITY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   output logic fall,
   output logic rise
);
   localparam int CW   = $clog2(FILT_LEN + 1);
   localparam int HALF = FILT_LEN / 2;

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_len
      $error("FILT_LEN must be at least 1");
   end
   if (FILT_MODE == sst_pkg::FILT_MAJORITY && (FILT_LEN % 2) == 0) begin : g_bad_odd
      $error("majority filter needs an odd FILT_LEN");
   end

   // Pipeline resets to low so that a line held low through reset
   // never produces a falling edge; a resulting rise is harmless.
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], scl_raw};
   end
   assign sync_out = sync_q[SYNC_STAGES-1];

   logic [FILT_LEN-1:0] win_q;
   logic                filt_d, filt_q, filt_prev;

   if (FILT_LEN == 1) begin : g_win1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) win_q <= '0;
         else        win_q <= sync_out;
      end
   end else begin : g_winn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) win_q <= '0;
         else        win_q <= {win_q[FILT_LEN-2:0], sync_out};
      end
   end

   if (FILT_MODE == sst_pkg::FILT_MAJORITY) begin : g_major
      logic [CW-1:0] ones;
      always_comb begin
         ones = '0;
         for (int i = 0; i < FILT_LEN; i++) ones = ones + CW'(win_q[i]);
         filt_d = (ones > CW'(HALF));
      end
   end else begin : g_unan
      always_comb begin
         if (&win_q)       filt_d = 1'b1;
         else if (~|win_q) filt_d = 1'b0;
         else              filt_d = filt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q    <= 1'b0;
         filt_prev <= 1'b0;
      end else begin
         filt_q    <= filt_d;
         filt_prev <= filt_q;
      end
   end

   assign fall = filt_prev & ~filt_q;
   assign rise = ~filt_prev & filt_q;
endmodule

// File: rtl/sst_low_timer.sv
module sst_low_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall,
   input  logic             rise,
   output logic             in_low_nxt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic [CNT_W-1:0] low_len
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_w
      $error("CNT_W must be at least 2");
   end

   logic             in_low;
   logic [CNT_W-1:0] cnt;

   always_comb begin
      in_low_nxt = in_low;
      cnt_nxt    = cnt;
      if (fall) begin
         in_low_nxt = 1'b1;
         cnt_nxt    = CNT_W'(1);
      end else if (rise) begin
         in_low_nxt = 1'b0;
         cnt_nxt    = '0;
      end else if (in_low) begin
         cnt_nxt    = (cnt == CNT_MAX) ? CNT_MAX : cnt + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_low  <= 1'b0;
         cnt     <= '0;
         low_len <= '0;
      end else begin
         in_low <= in_low_nxt;
         cnt    <= cnt_nxt;
         if (rise && in_low) low_len <= cnt;
      end
   end

   // R9
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_low && cnt == CNT_MAX && !rise && !fall) |=> (cnt == CNT_MAX));

   // R3
   len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(low_len));
endmodule

// File: rtl/sst_trigger_ctl.sv
module sst_trigger_ctl #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall,
   input  logic             in_low_nxt,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] thr_in,
   input  logic             arm,
   output logic             trig_pulse,
   output logic             trig_sticky
);
   logic [CNT_W-1:0] thr_act, thr_sel;
   logic             fired, fired_nxt, trig_d, arm_d, rearm;

   // threshold for this phase is captured at its falling edge
   assign thr_sel = fall ? thr_in : thr_act;
   assign trig_d  = arm & in_low_nxt & ~(fired & ~fall) & (cnt_nxt > thr_sel);
   assign fired_nxt = fall ? trig_d : (fired | trig_d);
   assign rearm   = arm & ~arm_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_act     <= '0;
         fired       <= 1'b0;
         trig_pulse  <= 1'b0;
         trig_sticky <= 1'b0;
         arm_d       <= 1'b0;
      end else begin
         thr_act    <= thr_sel;
         fired      <= fired_nxt;
         trig_pulse <= trig_d;
         arm_d      <= arm;
         if (trig_d)     trig_sticky <= 1'b1;
         else if (rearm) trig_sticky <= 1'b0;
      end
   end

   // R5
   one_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |=> !trig_pulse);

   // R6
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> trig_sticky);

   // R6
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_sticky && !rearm) |=> trig_sticky);

   // R7
   disarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> !trig_pulse);
endmodule

// File: rtl/scl_stretch_trigger.sv
module scl_stretch_trigger #(
   parameter int                  CNT_W       = 16,
   parameter int                  SYNC_STAGES = 2,
   parameter int                  FILT_LEN    = 3,
   parameter sst_pkg::filt_mode_e FILT_MODE   = sst_pkg::FILT_MAJORITY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic [CNT_W-1:0] thr_ticks,
   input  logic             arm,
   output logic             trig_pulse,
   output logic             trig_sticky,
   output logic [CNT_W-1:0] low_len
);
   logic             fall, rise, in_low_nxt;
   logic [CNT_W-1:0] cnt_nxt;

   sst_scl_conditioner #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .FILT_MODE  (FILT_MODE)
   ) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_raw(scl_in),
      .fall   (fall),
      .rise   (rise)
   );

   sst_low_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall      (fall),
      .rise      (rise),
      .in_low_nxt(in_low_nxt),
      .cnt_nxt   (cnt_nxt),
      .low_len   (low_len)
   );

   sst_trigger_ctl #(.CNT_W(CNT_W)) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall       (fall),
      .in_low_nxt (in_low_nxt),
      .cnt_nxt    (cnt_nxt),
      .thr_in     (thr_ticks),
      .arm        (arm),
      .trig_pulse (trig_pulse),
      .trig_sticky(trig_sticky)
   );
endmodule

// File: tb/tb_scl_stretch_trigger.sv
module tb_scl_stretch_trigger;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         scl = 1'b1;
   logic [W-1:0] thr = 8'd50;
   logic         arm = 1'b1;
   logic         trig_pulse, trig_sticky;
   logic [W-1:0] low_len;

   int checks = 0, errors = 0, cyc = 0;
   int trig_cnt = 0;
   int len_at_trig = -1;
   bit done = 1'b0;

   always #5 clk = ~clk;

   scl_stretch_trigger #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .thr_ticks(thr), .arm(arm),
      .trig_pulse(trig_pulse), .trig_sticky(trig_sticky), .low_len(low_len)
   );

   always @(negedge clk) begin
      if (rst_n && trig_pulse) begin
         trig_cnt    = trig_cnt + 1;
         len_at_trig = int'(low_len);
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: act=%0d expected below 100000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (12) @(negedge clk);
   endtask

   task automatic low_phase(input int n);
      @(negedge clk); scl = 1'b0;
      repeat (n) @(negedge clk);
      scl = 1'b1;
      settle();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 trig after reset", int'(trig_pulse), 0);
      check("R1 sticky after reset", int'(trig_sticky), 0);
      check("R1 low_len after reset", int'(low_len), 0);
      rst_n = 1'b1;
      settle();
   endtask

   task automatic t_threshold();
      thr = 8'd50; trig_cnt = 0;
      low_phase(40);
      check("R3 low_len 40", int'(low_len), 40);
      check("R4 below threshold", trig_cnt, 0);
      low_phase(50);
      check("R3 low_len 50", int'(low_len), 50);
      check("R4 equal threshold no fire", trig_cnt, 0);
      low_phase(51);
      check("R4 one over threshold fires", trig_cnt, 1);
      check("R6 sticky set", int'(trig_sticky), 1);
   endtask

   task automatic t_long();
      trig_cnt = 0;
      low_phase(150);
      check("R5 one pulse per long phase", trig_cnt, 1);
      check("R5 pulse before latch", len_at_trig, 51);
      check("R3 low_len 150", int'(low_len), 150);
   endtask

   task automatic t_disarm();
      arm = 1'b0; trig_cnt = 0;
      low_phase(100);
      check("R7 no trigger disarmed", trig_cnt, 0);
      check("R7 still measures", int'(low_len), 100);
      check("R6 sticky held while disarmed", int'(trig_sticky), 1);
      @(negedge clk); arm = 1'b1;
      repeat (2) @(negedge clk);
      check("R6 sticky cleared by re-arm", int'(trig_sticky), 0);
   endtask

   task automatic t_glitch();
      trig_cnt = 0;
      @(negedge clk); scl = 1'b0;
      @(negedge clk); scl = 1'b1;
      settle();
      check("R2 low glitch ignored", int'(low_len), 100);
      @(negedge clk); scl = 1'b0;
      repeat (30) @(negedge clk);
      scl = 1'b1;
      @(negedge clk); scl = 1'b0;
      repeat (29) @(negedge clk);
      scl = 1'b1;
      settle();
      check("R2 high glitch does not split", int'(low_len), 60);
      check("R2 no trigger from glitches", trig_cnt, 1);
   endtask

   task automatic t_thr_change();
      thr = 8'd50; trig_cnt = 0;
      @(negedge clk); scl = 1'b0;
      repeat (10) @(negedge clk);
      thr = 8'd200;
      repeat (70) @(negedge clk);
      scl = 1'b1;
      settle();
      check("R8 old threshold kept mid-phase", trig_cnt, 1);
      check("R3 low_len 80", int'(low_len), 80);
      trig_cnt = 0;
      low_phase(80);
      check("R8 new threshold at next fall", trig_cnt, 0);
   endtask

   task automatic t_saturate();
      thr = 8'd100; trig_cnt = 0;
      low_phase(300);
      check("R9 saturated length", int'(low_len), 255);
      check("R9 single trigger", trig_cnt, 1);
   endtask

   task automatic t_mid_reset();
      thr = 8'd50; trig_cnt = 0;
      @(negedge clk); scl = 1'b0;
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (100) @(negedge clk);
      scl = 1'b1;
      settle();
      check("R1 phase across reset not measured", int'(low_len), 0);
      check("R1 phase across reset no trigger", trig_cnt, 0);
      low_phase(70);
      check("R1 next phase measured", int'(low_len), 70);
      check("R1 next phase triggers", trig_cnt, 1);
   endtask

   initial begin
      t_reset();
      t_threshold();
      t_long();
      t_disarm();
      t_glitch();
      t_thr_change();
      t_saturate();
      t_mid_reset();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule